// File: doc/BRIEF.md
# Configuration reload CRC checker

This block refreshes a device's shadow configuration from a small non-volatile store each time the device drops into its fail-safe state. A one-cycle entry strobe starts a walk through the store. Each configuration word is copied to the shadow register that has the same index. The block folds the words into a CRC-8 as they arrive. When the walk ends, it compares the CRC with a reference word kept in the last location of the store.

The calculated CRC is published on a readback register. On a match, the channel enables follow the freshly loaded configuration and the active-low error pin stays released. On a mismatch, every channel is forced off, the error pin is pulled low, and two sticky flags are raised: one specific to the CRC and one general error flag. Software clears the flags with a clear input, but only once a later check has passed.

Top module: `cfgrl_top`

## Requirements
- R1: After the edge that samples `fs_enter` high, the block issues one store read per cycle on `rd_en`/`rd_addr`. The addresses run 0, 1, ... N_WORDS-1 in ascending order, and the last address holds the reference CRC. The store returns `rd_data` one cycle after each read.
- R2: Each configuration word at address 0..N_WORDS-2 is written once to the shadow port with `shd_addr` equal to its store address and `shd_data` equal to its stored value. Address N_WORDS-1 is never written.
- R3: The CRC is CRC-8 with polynomial 0x07 and initial value 0xFF. It processes words 0..N_WORDS-2 in address order, each word MSB first, and excludes the reference word. The result appears on `calc_crc` when `done` rises and holds until the next completed check.
- R4: `done` is a single-cycle pulse. It is high in the cycle after the (N_WORDS+2)-th clock edge that follows the edge which sampled the strobe.
- R5: After a mismatching check, `ch_en` is all zero and `err_n` is low.
- R6: After a mismatching check, `flag_crc` and `flag_err` are both 1.
- R7: The flags stay set until `flag_clr` is high after a check that matched. A `flag_clr` while the latest check mismatched leaves both flags at 1.
- R8: After a matching check, `ch_en` equals bits [CH_N-1:0] of configuration word 0 and `err_n` is high.
- R9: An `fs_enter` that arrives while a reload or check is in progress restarts the read walk at address 0. The aborted run produces no `done`.
- R10: After reset, `done`, `ch_en`, `calc_crc` and both flags are 0, and `err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_enter | input | 1 | Fail-safe entry strobe |
| rd_en | output | 1 | Store read request |
| rd_addr | output | AW | Store read address |
| rd_data | input | WORD_W | Store read data, one cycle after `rd_en` |
| shd_we | output | 1 | Shadow register write enable |
| shd_addr | output | AW | Shadow register index |
| shd_data | output | WORD_W | Shadow register write data |
| calc_crc | output | 8 | Calculated CRC readback |
| ch_en | output | CH_N | Channel enables |
| err_n | output | 1 | Active-low error pin |
| flag_clr | input | 1 | Fault flag clear request |
| flag_crc | output | 1 | Sticky CRC fault flag |
| flag_err | output | 1 | Sticky general error flag |
| done | output | 1 | Check-complete pulse |

## Verification
The assertions check several rules on every cycle:
- a low error pin always comes with both flags set and all channels off;
- shadow writes never target the reference address;
- reads step up by one address per cycle, and a strobe always restarts them at address 0;
- `done` lasts one cycle, the readback changes only with `done`, and the flags hold unless cleared.

Other behaviour only the bench's scenarios can show. These are the CRC value itself over many store contents, the mapping of shadow data to store contents, the exact latency of `done`, the enables taken from word 0, the refusal of a clear while a mismatch stands, and the missing `done` for an aborted walk.

// File: rtl/cfgrl_pkg.sv
// Package: shared constants and state type for the configuration reload checker.
package cfgrl_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_CHECK = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cfgrl_seq.sv
// Module: cfgrl_seq
// Walks the store addresses 0..N_WORDS-1 after each fail-safe strobe and tracks
// the one-cycle read latency. It raises chk_go in the cycle the comparison is due.
// Assumes: the store answers every read exactly one cycle later.
module cfgrl_seq
    import cfgrl_pkg::*;
#(
    parameter int N_WORDS = 8,
    localparam int AW = $clog2(N_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_enter,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rsp_vld,
    output logic [AW-1:0] rsp_addr,
    output logic          chk_go
);
    localparam logic [AW-1:0] LAST = AW'(N_WORDS - 1);

    seq_state_t    state;
    logic [AW-1:0] addr;

    assign rd_en   = (state == ST_LOAD);
    assign rd_addr = addr;
    assign chk_go  = (state == ST_CHECK) && !fs_enter;

    // Step the state machine; a strobe restarts the walk from any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else if (fs_enter) begin
            state <= ST_LOAD;
            addr  <= '0;
        end else begin
            case (state)
                ST_LOAD: begin
                    if (addr == LAST) state <= ST_DRAIN;
                    else              addr  <= addr + 1'b1;
                end
                ST_DRAIN: state <= ST_CHECK;
                ST_CHECK: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Track which address the store is answering this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_addr <= '0;
        end else begin
            rsp_vld  <= rd_en && !fs_enter;
            rsp_addr <= addr;
        end
    end
endmodule

// File: rtl/cfgrl_crc.sv
// Module: cfgrl_crc
// Bit-serial CRC-8 accumulator unrolled over one word per cycle, MSB first.
// Assumes: init and upd_en are never needed in the same cycle (init wins).
module cfgrl_crc
    import cfgrl_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd_en,
    input  logic [WORD_W-1:0] upd_word,
    output logic [CRC_W-1:0]  crc_q
);
    logic [CRC_W-1:0] stage [WORD_W+1];

    assign stage[0] = crc_q;

    // One generated stage per data bit, starting with the word's MSB.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][CRC_W-1] ^ upd_word[WORD_W-1-b];
        assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    // Load the seed on a strobe, otherwise fold in the incoming word.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc_q <= CRC_INIT;
        else if (upd_en)    crc_q <= stage[WORD_W];
    end
endmodule

// File: rtl/cfgrl_judge.sv
// Module: cfgrl_judge
// Captures the reference word and the channel configuration. It compares the
// CRCs, then drives the enables, the error pin, the sticky flags and done.
// Assumes: CH_N <= WORD_W; word 0 carries the channel enables in its low bits.
module cfgrl_judge
    import cfgrl_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 8,
    parameter int CH_N    = 8,
    localparam int AW = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_vld,
    input  logic [AW-1:0]     rsp_addr,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic [CRC_W-1:0]  crc_q,
    input  logic              chk_go,
    input  logic              flag_clr,
    output logic [CRC_W-1:0]  calc_crc,
    output logic [CH_N-1:0]   ch_en,
    output logic              err_n,
    output logic              flag_crc,
    output logic              flag_err,
    output logic              done
);
    localparam logic [AW-1:0] LAST = AW'(N_WORDS - 1);

    logic [CRC_W-1:0] ref_q;
    logic [CH_N-1:0]  ch_cfg;
    logic             mismatch;
    logic             bad_now;

    assign bad_now = (crc_q != ref_q[CRC_W-1:0]);
    assign ch_en   = mismatch ? '0 : ch_cfg;
    assign err_n   = !mismatch;

    // Keep the reference word and the loaded channel configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            ch_cfg <= '0;
        end else if (rsp_vld) begin
            if (rsp_addr == LAST)  ref_q  <= CRC_W'(rsp_word);
            if (rsp_addr == '0)    ch_cfg <= rsp_word[CH_N-1:0];
        end
    end

    // Publish the result of each completed check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_crc <= '0;
            mismatch <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= chk_go;
            if (chk_go) begin
                calc_crc <= crc_q;
                mismatch <= bad_now;
            end
        end
    end

    // Sticky flags: a set wins, and a clear counts only after a passing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_crc <= 1'b0;
            flag_err <= 1'b0;
        end else if (chk_go && bad_now) begin
            flag_crc <= 1'b1;
            flag_err <= 1'b1;
        end else if (flag_clr && !mismatch) begin
            flag_crc <= 1'b0;
            flag_err <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgrl_top.sv
// Module: cfgrl_top
// Reloads the shadow configuration on every fail-safe entry and checks it
// against the stored CRC. On a mismatch it shuts the channels off and reports a fault.
// Assumes: the store has N_WORDS words, and the last one is the reference CRC.
module cfgrl_top
    import cfgrl_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 8,
    parameter int CH_N    = 8,
    localparam int AW = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_enter,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              shd_we,
    output logic [AW-1:0]     shd_addr,
    output logic [WORD_W-1:0] shd_data,
    output logic [7:0]        calc_crc,
    output logic [CH_N-1:0]   ch_en,
    output logic              err_n,
    input  logic              flag_clr,
    output logic              flag_crc,
    output logic              flag_err,
    output logic              done
);
    localparam logic [AW-1:0] LAST = AW'(N_WORDS - 1);

    logic          rsp_vld;
    logic [AW-1:0] rsp_addr;
    logic          chk_go;
    logic          crc_upd;
    logic [CRC_W-1:0] crc_q;

    assign shd_we   = rsp_vld && (rsp_addr != LAST);
    assign shd_addr = rsp_addr;
    assign shd_data = rd_data;
    assign crc_upd  = shd_we;

    cfgrl_seq #(.N_WORDS(N_WORDS)) seq_i (
        .clk(clk), .rst_n(rst_n), .fs_enter(fs_enter),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .chk_go(chk_go)
    );

    cfgrl_crc #(.WORD_W(WORD_W)) crc_i (
        .clk(clk), .rst_n(rst_n), .init(fs_enter),
        .upd_en(crc_upd), .upd_word(rd_data), .crc_q(crc_q)
    );

    cfgrl_judge #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .CH_N(CH_N)) judge_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_word(rd_data),
        .crc_q(crc_q), .chk_go(chk_go), .flag_clr(flag_clr),
        .calc_crc(calc_crc), .ch_en(ch_en), .err_n(err_n),
        .flag_crc(flag_crc), .flag_err(flag_err), .done(done)
    );
endmodule

// File: rtl/cfgrl_chk.sv
// Module: cfgrl_chk
// Cycle-level rules of the reload checker, bound onto cfgrl_top.
module cfgrl_chk #(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 8,
    parameter int CH_N    = 8,
    localparam int AW = $clog2(N_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_enter,
    input logic              rd_en,
    input logic [AW-1:0]     rd_addr,
    input logic              shd_we,
    input logic [AW-1:0]     shd_addr,
    input logic [7:0]        calc_crc,
    input logic [CH_N-1:0]   ch_en,
    input logic              err_n,
    input logic              flag_clr,
    input logic              flag_crc,
    input logic              flag_err,
    input logic              done
);
    p_walk_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !$past(fs_enter)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

    p_no_ref_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shd_we |-> (shd_addr != AW'(N_WORDS - 1)));

    p_crc_moves_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(calc_crc) |-> done);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_off_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> (ch_en == '0));

    p_flags_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> (flag_crc && flag_err));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_crc && !flag_clr) |=> flag_crc);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fs_enter |=> (rd_en && rd_addr == '0));
endmodule

bind cfgrl_top cfgrl_chk #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .CH_N(CH_N)) chk_i (
    .clk(clk), .rst_n(rst_n), .fs_enter(fs_enter), .rd_en(rd_en), .rd_addr(rd_addr),
    .shd_we(shd_we), .shd_addr(shd_addr), .calc_crc(calc_crc), .ch_en(ch_en),
    .err_n(err_n), .flag_clr(flag_clr), .flag_crc(flag_crc), .flag_err(flag_err),
    .done(done)
);

// File: tb/cfgrl_top_tb_top.sv
module cfgrl_top_tb_top;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int CH = 8;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fs_enter = 1'b0;
    logic          flag_clr = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [W-1:0]  rd_data = '0;
    logic          shd_we;
    logic [AW-1:0] shd_addr;
    logic [W-1:0]  shd_data;
    logic [7:0]    calc_crc;
    logic [CH-1:0] ch_en;
    logic          err_n, flag_crc, flag_err, done;

    logic [W-1:0] mem [N];
    logic [W-1:0] shadow [N];
    int wr_cnt = 0;
    int wr_order_bad = 0;
    int ref_wr = 0;
    int done_cnt = 0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cfgrl_top #(.N_WORDS(N), .WORD_W(W), .CH_N(CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fs_enter(fs_enter),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .shd_we(shd_we), .shd_addr(shd_addr), .shd_data(shd_data),
        .calc_crc(calc_crc), .ch_en(ch_en), .err_n(err_n),
        .flag_clr(flag_clr), .flag_crc(flag_crc), .flag_err(flag_err), .done(done)
    );

    // Store model: synchronous read, one cycle latency.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // Record shadow writes and done pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && shd_we) begin
            if (int'(shd_addr) == N - 1) ref_wr++;
            else begin
                if (int'(shd_addr) != wr_cnt) wr_order_bad++;
                shadow[shd_addr] = shd_data;
            end
            wr_cnt++;
        end
        if (rst_n && done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_model();
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < N - 1; i++)
            for (int b = W - 1; b >= 0; b--) begin
                logic fb = c[7] ^ mem[i][b];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        return c;
    endfunction

    task automatic strobe();
        fs_enter = 1'b1;
        @(negedge clk);
        fs_enter = 1'b0;
        wr_cnt = 0;
        wr_order_bad = 0;
        ref_wr = 0;
        done_cnt = 0;
    endtask

    // Run one full check and verify timing, shadow contents and outcome.
    task automatic run_check(input bit exp_bad, input bit exp_flag);
        logic [7:0] ec = crc_model();
        strobe();
        repeat (N + 1) @(negedge clk);
        chk(done == 1'b0, "R4 done early", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R4 done latency", done, 1);
        chk(calc_crc == ec, "R3 crc value", calc_crc, ec);
        chk(wr_cnt == N - 1 && wr_order_bad == 0, "R1 R2 write walk", wr_cnt, N - 1);
        chk(ref_wr == 0, "R2 ref never written", ref_wr, 0);
        for (int i = 0; i < N - 1; i++)
            if (shadow[i] !== mem[i]) chk(0, "R2 shadow data", shadow[i], mem[i]);
        if (exp_bad) begin
            chk(ch_en == '0 && err_n == 1'b0, "R5 off and err", {ch_en, err_n}, 0);
            chk(flag_crc && flag_err, "R6 flags set", {flag_crc, flag_err}, 3);
        end else begin
            chk(ch_en == mem[0][CH-1:0] && err_n, "R8 enables on match",
                {ch_en, err_n}, {mem[0][CH-1:0], 1'b1});
            chk(flag_crc == exp_flag && flag_err == exp_flag, "R7 sticky flags",
                {flag_crc, flag_err}, {exp_flag, exp_flag});
        end
        @(negedge clk);
        chk(done == 1'b0, "R4 done one cycle", done, 0);
    endtask

    task automatic fill(input int seed, input bit corrupt);
        for (int i = 0; i < N - 1; i++) mem[i] = W'(seed * 37 + i * 91 + 13 + seed * i);
        mem[N - 1] = crc_model();
        if (corrupt) mem[N - 1] = mem[N - 1] ^ W'(1 << (seed % W));
    endtask

    task automatic clear_pulse();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit flag_exp;
        for (int i = 0; i < N; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!done && ch_en == '0 && calc_crc == 8'h00 && !flag_crc && !flag_err && err_n,
            "R10 reset state", {done, ch_en, calc_crc, flag_crc, flag_err, err_n}, 1);

        // Sweep of store contents: every third set carries a wrong reference.
        flag_exp = 1'b0;
        for (int s = 0; s < 48; s++) begin
            bit corrupt = (s % 3 == 0);
            fill(s, corrupt);
            if (corrupt) flag_exp = 1'b1;
            run_check(corrupt, flag_exp);
            clear_pulse();
            if (corrupt) begin
                // R7 clear refused while mismatch stands
                chk(flag_crc && flag_err, "R7 clear ignored on mismatch", {flag_crc, flag_err}, 3);
                chk(ch_en == '0 && !err_n, "R7 R5 outputs held", {ch_en, err_n}, 0);
            end else begin
                flag_exp = 1'b0;
                chk(!flag_crc && !flag_err, "R7 clear after match", {flag_crc, flag_err}, 0);
            end
        end

        // R9 restart during the walk, with new contents for the second run.
        fill(100, 1'b1);
        strobe();
        repeat (3) @(negedge clk);
        fill(101, 1'b0);
        run_check(1'b0, flag_crc);
        chk(done_cnt == 1, "R9 no done from aborted walk", done_cnt, 1);

        // R9 strobe in the check cycle cancels that run's done.
        fill(102, 1'b1);
        strobe();
        repeat (N + 1) @(negedge clk);
        fill(103, 1'b0);
        run_check(1'b0, flag_crc);
        chk(done_cnt == 1, "R9 strobe at check cancels done", done_cnt, 1);
        chk(err_n == 1'b1, "R9 latest run decides", err_n, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule